// File: doc/BRIEF.md
# ADC Control and Result Register Interface

This block is the digital side of a 10-bit successive-approximation analog-to-digital converter. A small register bus reaches three byte registers. The control/status register holds a channel number, an enable bit and an end-of-conversion flag. The other two registers hold the upper eight and the lower two bits of the most recent result. Behind the registers, a sequencer drives the analog front end. It selects a channel, holds a sampling window, and then presents one trial code per cycle to an external comparator. The comparator answers with a single bit.

Setting the enable bit powers the front end and starts conversion. From then on the selected channel is converted again and again until enable is cleared. Software can poll the flag and read the low byte, then the high byte. Reading the high byte drops the flag. Software that needs only eight bits reads the high byte alone. The result registers have no shadow copy. If software is slow, a later conversion replaces both bytes while it is between its two reads.

Top module: `adc_regif`

## Requirements
- R1: After reset, all three registers read 0x00 and `ana_pwr` is 0.
- R2: Address 0 is the control/status register. Bits [3:0] hold the channel, bit 5 is enable, bit 7 is the end-of-conversion flag and is read-only, and bits 4 and 6 read 0. A write that sets bit 7 leaves the flag unchanged.
- R3: While enabled, each conversion is `SAMPLE_CYCLES` cycles with `ana_sample` high, followed by `RES_BITS` trial cycles. A new conversion follows at once, so sampling windows begin every `SAMPLE_CYCLES+RES_BITS` cycles.
- R4: Trial bits are decided from the most significant bit down to the least. A bit is kept when `ana_cmp` is 1, and `ana_cmp` means the input is at or above `ana_trial`. A full-scale input gives 0x3FF, which reads as 0xFF high and 0x03 low with no overflow flag. An input at or below zero gives 0.
- R5: Address 1 reads result bits [9:2]. Address 2 reads result bits [1:0] in its bits [1:0], and its bits [7:2] read 0.
- R6: The flag sets in the cycle after a conversion completes. It stays set when further conversions complete.
- R7: A read of address 1 clears the flag. Reads of addresses 0 and 2 leave it set. If a conversion completes in the same cycle as a read of address 1, the flag stays set.
- R8: A completing conversion overwrites both result bytes, even when only the low byte of the previous result has been read.
- R9: Clearing enable aborts a conversion in progress and sends the sequencer idle with `ana_sample` low. The result bytes and the flag keep their values.
- R10: The channel is taken from the register when each conversion starts, and `ana_chan` is stable during trial cycles. A channel written during a conversion is used from the next conversion on.
- R11: For a constant input, the result equals the input code clamped to 0..1023. Across a rising sweep of inputs, the results never decrease.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register address: 0 control/status, 1 result high, 2 result low |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read; a read of address 1 clears the flag |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| ana_pwr | output | 1 | Front-end power, follows the enable bit |
| ana_chan | output | CHAN_BITS | Channel being converted |
| ana_sample | output | 1 | High during the sampling window |
| ana_trial | output | RES_BITS | Trial code presented to the comparator |
| ana_cmp | input | 1 | Comparator answer: 1 when the input is at or above `ana_trial` |

## Verification
The checker assumes that a bus read and a bus write never share a cycle, and that each strobe lasts exactly one clock. It also assumes that `ana_cmp` comes only from the current trial code and the level on the selected channel. The bench holds one threshold value per channel and models the comparator as an integer comparison against the trial code. It changes a level only between conversions, except in the deliberate overwrite and abort cases. After any change of level or channel, it discards the first result so that no result mixes two inputs. All bus strobes are driven from tasks, one at a time.

// File: rtl/adc_regif_pkg.sv
package adc_regif_pkg;
   typedef enum logic [1:0] {
      SEQ_IDLE   = 2'd0,
      SEQ_SAMPLE = 2'd1,
      SEQ_CONV   = 2'd2
   } seq_state_e;

   localparam logic [1:0] ADDR_CSR = 2'd0;
   localparam logic [1:0] ADDR_HI  = 2'd1;
   localparam logic [1:0] ADDR_LO  = 2'd2;

   localparam int BUS_W       = 8;
   localparam int CSR_EN_BIT  = 5;
   localparam int CSR_EOC_BIT = 7;
endpackage

// File: rtl/adc_sar_seq.sv
module adc_sar_seq
   import adc_regif_pkg::*;
#(
   parameter int RES_BITS      = 10,
   parameter int CHAN_BITS     = 4,
   parameter int SAMPLE_CYCLES = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en_i,
   input  logic [CHAN_BITS-1:0] chan_i,
   input  logic                 cmp_i,
   output logic [CHAN_BITS-1:0] chan_o,
   output logic                 sample_o,
   output logic [RES_BITS-1:0]  trial_o,
   output logic                 done_o,
   output logic [RES_BITS-1:0]  code_o,
   output seq_state_e           state_o
);
   localparam int CNT_W = (SAMPLE_CYCLES > 1) ? $clog2(SAMPLE_CYCLES) : 1;
   localparam int BIT_W = $clog2(RES_BITS);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SAMPLE_CYCLES - 1);
   localparam logic [BIT_W-1:0] BIT_TOP  = BIT_W'(RES_BITS - 1);

   if (SAMPLE_CYCLES < 1) begin : g_bad_sample
      $error("adc_sar_seq: SAMPLE_CYCLES must be at least 1");
   end

   seq_state_e           state_q;
   logic [CNT_W-1:0]     cnt_q;
   logic [BIT_W-1:0]     bit_q;
   logic [RES_BITS-1:0]  acc_q;
   logic [CHAN_BITS-1:0] chan_q;
   logic [RES_BITS-1:0]  bit_mask;
   logic [RES_BITS-1:0]  trial;
   logic [RES_BITS-1:0]  keep;
   logic                 in_conv;

   assign in_conv  = (state_q == SEQ_CONV);
   assign bit_mask = {{(RES_BITS-1){1'b0}}, 1'b1} << bit_q;
   assign trial    = in_conv ? (acc_q | bit_mask) : '0;
   assign keep     = cmp_i ? trial : acc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         cnt_q   <= '0;
         bit_q   <= '0;
         acc_q   <= '0;
         chan_q  <= '0;
      end else if (!en_i) begin
         state_q <= SEQ_IDLE;
         cnt_q   <= '0;
         bit_q   <= '0;
         acc_q   <= '0;
      end else begin
         unique case (state_q)
            SEQ_IDLE: begin
               state_q <= SEQ_SAMPLE;
               cnt_q   <= '0;
               chan_q  <= chan_i;
            end
            SEQ_SAMPLE: begin
               if (cnt_q == CNT_LAST) begin
                  state_q <= SEQ_CONV;
                  bit_q   <= BIT_TOP;
                  acc_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            SEQ_CONV: begin
               acc_q <= keep;
               if (bit_q == '0) begin
                  state_q <= SEQ_SAMPLE;
                  cnt_q   <= '0;
                  chan_q  <= chan_i;
               end else begin
                  bit_q <= bit_q - 1'b1;
               end
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   assign chan_o   = chan_q;
   assign sample_o = (state_q == SEQ_SAMPLE);
   assign trial_o  = trial;
   assign done_o   = en_i && in_conv && (bit_q == '0);
   assign code_o   = keep;
   assign state_o  = state_q;
endmodule

// File: rtl/adc_csr.sv
module adc_csr
   import adc_regif_pkg::*;
#(
   parameter int CHAN_BITS = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_i,
   input  logic                 rd_i,
   input  logic [1:0]           addr_i,
   input  logic [BUS_W-1:0]     wdata_i,
   input  logic                 done_i,
   output logic [CHAN_BITS-1:0] chan_o,
   output logic                 en_o,
   output logic                 eoc_o
);
   localparam logic [BUS_W-1:0] USED_MASK =
      BUS_W'((1 << CHAN_BITS) - 1) | BUS_W'(1 << CSR_EN_BIT);

   logic unused_wbits;
   assign unused_wbits = ^(wdata_i & ~USED_MASK);

   logic csr_wr;
   logic hi_rd;
   assign csr_wr = wr_i && (addr_i == ADDR_CSR);
   assign hi_rd  = rd_i && (addr_i == ADDR_HI);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chan_o <= '0;
         en_o   <= 1'b0;
      end else if (csr_wr) begin
         chan_o <= wdata_i[CHAN_BITS-1:0];
         en_o   <= wdata_i[CSR_EN_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      eoc_o <= 1'b0;
      else if (done_i) eoc_o <= 1'b1;
      else if (hi_rd)  eoc_o <= 1'b0;
   end
endmodule

// File: rtl/adc_result.sv
module adc_result
   import adc_regif_pkg::*;
#(
   parameter int RES_BITS = 10
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                done_i,
   input  logic [RES_BITS-1:0] code_i,
   output logic [RES_BITS-1:0] res_o,
   output logic [BUS_W-1:0]    hi_o,
   output logic [BUS_W-1:0]    lo_o
);
   localparam int LO_W = RES_BITS - BUS_W;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      res_o <= '0;
      else if (done_i) res_o <= code_i;
   end

   assign hi_o = res_o[RES_BITS-1 -: BUS_W];

   if (LO_W == BUS_W) begin : g_lo_full
      assign lo_o = res_o[LO_W-1:0];
   end else begin : g_lo_pad
      assign lo_o = {{(BUS_W-LO_W){1'b0}}, res_o[LO_W-1:0]};
   end
endmodule

// File: rtl/adc_regif.sv
module adc_regif
   import adc_regif_pkg::*;
#(
   parameter int RES_BITS      = 10,
   parameter int CHAN_BITS     = 4,
   parameter int SAMPLE_CYCLES = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [1:0]           bus_addr,
   input  logic                 bus_wr,
   input  logic                 bus_rd,
   input  logic [7:0]           bus_wdata,
   output logic [7:0]           bus_rdata,
   output logic                 ana_pwr,
   output logic [CHAN_BITS-1:0] ana_chan,
   output logic                 ana_sample,
   output logic [RES_BITS-1:0]  ana_trial,
   input  logic                 ana_cmp
);
   if (RES_BITS <= BUS_W || RES_BITS > 2 * BUS_W) begin : g_bad_res
      $error("adc_regif: RES_BITS must lie in 9..16");
   end
   if (CHAN_BITS < 1 || CHAN_BITS > CSR_EN_BIT - 1) begin : g_bad_chan
      $error("adc_regif: CHAN_BITS must lie in 1..4");
   end

   logic [CHAN_BITS-1:0] csr_chan;
   logic                 csr_en;
   logic                 eoc;
   logic                 seq_done;
   logic [RES_BITS-1:0]  seq_code;
   seq_state_e           seq_state;
   logic [RES_BITS-1:0]  res;
   logic [BUS_W-1:0]     res_hi;
   logic [BUS_W-1:0]     res_lo;
   logic [BUS_W-1:0]     csr_word;

   adc_csr #(.CHAN_BITS(CHAN_BITS)) csr_i (
      .clk(clk), .rst_n(rst_n), .wr_i(bus_wr), .rd_i(bus_rd),
      .addr_i(bus_addr), .wdata_i(bus_wdata), .done_i(seq_done),
      .chan_o(csr_chan), .en_o(csr_en), .eoc_o(eoc)
   );

   adc_sar_seq #(
      .RES_BITS(RES_BITS), .CHAN_BITS(CHAN_BITS), .SAMPLE_CYCLES(SAMPLE_CYCLES)
   ) seq_i (
      .clk(clk), .rst_n(rst_n), .en_i(csr_en), .chan_i(csr_chan),
      .cmp_i(ana_cmp), .chan_o(ana_chan), .sample_o(ana_sample),
      .trial_o(ana_trial), .done_o(seq_done), .code_o(seq_code),
      .state_o(seq_state)
   );

   adc_result #(.RES_BITS(RES_BITS)) res_i (
      .clk(clk), .rst_n(rst_n), .done_i(seq_done), .code_i(seq_code),
      .res_o(res), .hi_o(res_hi), .lo_o(res_lo)
   );

   always_comb begin
      csr_word                   = '0;
      csr_word[CHAN_BITS-1:0]    = csr_chan;
      csr_word[CSR_EN_BIT]       = csr_en;
      csr_word[CSR_EOC_BIT]      = eoc;
   end

   always_comb begin
      unique case (bus_addr)
         ADDR_CSR: bus_rdata = csr_word;
         ADDR_HI:  bus_rdata = res_hi;
         ADDR_LO:  bus_rdata = res_lo;
         default:  bus_rdata = '0;
      endcase
   end

   assign ana_pwr = csr_en;
endmodule

// File: rtl/adc_regif_chk.sv
module adc_regif_chk
   import adc_regif_pkg::*;
#(
   parameter int RES_BITS      = 10,
   parameter int CHAN_BITS     = 4,
   parameter int SAMPLE_CYCLES = 3
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [1:0]           bus_addr,
   input logic                 bus_rd,
   input logic [7:0]           bus_rdata,
   input logic                 ana_pwr,
   input logic [CHAN_BITS-1:0] ana_chan,
   input logic                 ana_sample,
   input logic [RES_BITS-1:0]  ana_trial,
   input seq_state_e           seq_state,
   input logic                 seq_done,
   input logic                 eoc,
   input logic [RES_BITS-1:0]  res
);
   localparam int PERIOD = SAMPLE_CYCLES + RES_BITS;
   localparam int PCW    = $clog2(PERIOD + 1);
   localparam int LO_W   = RES_BITS - BUS_W;

   logic [PCW-1:0] per_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      per_cnt <= '0;
      else if (seq_state == SEQ_IDLE)  per_cnt <= '0;
      else if (seq_done)               per_cnt <= '0;
      else                             per_cnt <= per_cnt + 1'b1;
   end

   AST_EOC_SET: assert property (@(posedge clk) disable iff (!rst_n)
      seq_done |=> eoc);                                                  // R6
   AST_EOC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == ADDR_HI && !seq_done) |=> !eoc);             // R7
   AST_EOC_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (eoc && !(bus_rd && bus_addr == ADDR_HI)) |=> eoc);                 // R7
   AST_LO_PAD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_LO) |-> (bus_rdata[BUS_W-1:LO_W] == '0));         // R5
   AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !ana_pwr |=> ($stable(res) && !ana_sample));                        // R9
   AST_CHAN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_state == SEQ_CONV) |-> $stable(ana_chan));                     // R10
   AST_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
      seq_done |-> (per_cnt == PCW'(PERIOD - 1)));                        // R3
   AST_TRIAL_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_state == SEQ_CONV) |-> (ana_trial != '0));                     // R4
endmodule

bind adc_regif adc_regif_chk #(
   .RES_BITS(RES_BITS), .CHAN_BITS(CHAN_BITS), .SAMPLE_CYCLES(SAMPLE_CYCLES)
) chk_i (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
   .bus_rdata(bus_rdata), .ana_pwr(ana_pwr), .ana_chan(ana_chan),
   .ana_sample(ana_sample), .ana_trial(ana_trial), .seq_state(seq_state),
   .seq_done(seq_done), .eoc(eoc), .res(res)
);

// File: tb/adc_regif_tb_top.sv
`timescale 1ns/1ps
module adc_regif_tb_top;
   localparam int RB = 10;
   localparam int CB = 4;
   localparam int SC = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    bus_addr = '0;
   logic          bus_wr = 1'b0;
   logic          bus_rd = 1'b0;
   logic [7:0]    bus_wdata = '0;
   logic [7:0]    bus_rdata;
   logic          ana_pwr;
   logic [CB-1:0] ana_chan;
   logic          ana_sample;
   logic [RB-1:0] ana_trial;
   logic          ana_cmp;

   int chan_val [16];
   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   assign ana_cmp = (chan_val[ana_chan] >= int'(ana_trial));

   adc_regif #(.RES_BITS(RB), .CHAN_BITS(CB), .SAMPLE_CYCLES(SC)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ana_pwr(ana_pwr), .ana_chan(ana_chan), .ana_sample(ana_sample),
      .ana_trial(ana_trial), .ana_cmp(ana_cmp)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic wait_eoc(input string req);
      logic [7:0] v;
      bit seen = 1'b0;
      for (int i = 0; i < 100; i++) begin
         bus_read(2'd0, v);
         if (v[7]) begin
            seen = 1'b1;
            break;
         end
      end
      if (!seen) check(req, 0, 1);
   endtask

   task automatic read_code(output int code);
      logic [7:0] lo, hi;
      bus_read(2'd2, lo);
      bus_read(2'd1, hi);
      code = (int'(hi) << 2) | int'(lo);
   endtask

   // discard the result that may span a level change, then wait for a clean one
   task automatic fresh_conv(input string req);
      logic [7:0] d;
      bus_read(2'd1, d);
      wait_eoc(req);
      bus_read(2'd1, d);
      wait_eoc(req);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual 0x0 expected 0x1");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      int code, prev, cnt;
      for (int i = 0; i < 16; i++) chan_val[i] = i * 61 + 5;

      repeat (5) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      bus_read(2'd0, d); check("R1 csr", d, 0);
      bus_read(2'd1, d); check("R1 hi", d, 0);
      bus_read(2'd2, d); check("R1 lo", d, 0);
      check("R1 pwr", ana_pwr, 0);

      // R2 flag bit is read-only, spare bits read zero
      bus_write(2'd0, 8'hDA);
      bus_read(2'd0, d); check("R2 csr readback", d, 8'h0A);
      check("R2 pwr off", ana_pwr, 0);

      // enable on channel 3
      bus_write(2'd0, 8'h23);
      bus_read(2'd0, d); check("R2 csr enabled", d & 8'h7F, 8'h23);
      check("R2 pwr on", ana_pwr, 1);

      wait_eoc("R6 first eoc");
      bus_read(2'd2, d);
      bus_read(2'd0, d); check("R7 lo read keeps eoc", d[7], 1);
      fresh_conv("R4 ch3");
      read_code(code); check("R4 ch3 value", code, chan_val[3]);
      bus_read(2'd0, d); check("R7 hi read clears eoc", d[7], 0);

      // R3 sampling window length and repeat period
      @(negedge clk);
      while (ana_sample) @(negedge clk);
      while (!ana_sample) @(negedge clk);
      cnt = 0;
      while (ana_sample) begin cnt++; @(negedge clk); end
      check("R3 sample length", cnt, SC);
      while (!ana_sample) begin cnt++; @(negedge clk); end
      check("R3 period", cnt, SC + RB);

      // R6 flag stays set across further completions
      wait_eoc("R6 eoc");
      repeat (45) @(negedge clk);
      bus_read(2'd0, d); check("R6 eoc held", d[7], 1);

      // R8 overwrite between the two reads
      chan_val[3] = 341;
      fresh_conv("R8 setup");
      bus_read(2'd2, d); check("R8 first lo", d, 341 & 3);
      chan_val[3] = 682;
      repeat (45) @(negedge clk);
      bus_read(2'd1, d); check("R8 overwritten hi", d, 682 >> 2);
      bus_read(2'd2, d); check("R8 overwritten lo", d, 682 & 3);

      // R10 channel change takes effect at the next conversion
      bus_read(2'd1, d);
      wait_eoc("R10 sync");
      bus_write(2'd0, 8'h25);
      bus_read(2'd1, d);
      wait_eoc("R10 old");
      read_code(code); check("R10 conversion in flight uses old channel", code, chan_val[3]);
      wait_eoc("R10 new");
      read_code(code); check("R10 next conversion uses new channel", code, chan_val[5]);
      check("R10 ana_chan", ana_chan, 5);

      // R4 extremes
      chan_val[5] = 5000;
      fresh_conv("R4 full");
      bus_read(2'd1, d); check("R4 full scale hi", d, 8'hFF);
      bus_read(2'd2, d); check("R4 full scale lo", d, 8'h03);
      chan_val[5] = -7;
      fresh_conv("R4 low");
      read_code(code); check("R4 below zero", code, 0);

      // R11 rising sweep over every code
      prev = 0;
      for (int v = 0; v < 1024; v++) begin
         chan_val[5] = v;
         fresh_conv("R11 sweep");
         read_code(code);
         check("R11 code", code, v);
         if (code < prev) check("R11 monotonic", code, prev);
         prev = code;
      end

      // R9 abort in the middle of trial cycles
      chan_val[5] = 300;
      fresh_conv("R9 setup");
      read_code(code); check("R9 before abort", code, 300);
      @(negedge clk);
      while (!(ana_trial != '0 && !ana_sample)) @(negedge clk);
      chan_val[5] = 900;
      bus_write(2'd0, 8'h05);
      repeat (50) @(negedge clk);
      bus_read(2'd0, d); check("R9 csr after abort", d, 8'h05);
      bus_read(2'd1, d); check("R9 hi kept", d, 300 >> 2);
      bus_read(2'd2, d); check("R9 lo kept", d, 300 & 3);
      check("R9 sample low", ana_sample, 0);
      bus_write(2'd0, 8'h25);
      fresh_conv("R9 restart");
      read_code(code); check("R9 restart value", code, 900);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule